// File: doc/BRIEF.md
# Receive Ring Consumer and Refill Engine

This block manages the host side of a circular receive descriptor ring in hardware. A producer elsewhere fills descriptors in ring order and marks them full. The engine keeps two pointers of its own. The tail pointer takes full descriptors, passes each one downstream through a valid/ready handshake, and marks it not-in-use. The head pointer follows the tail. It attaches a fresh buffer to each not-in-use descriptor and marks it empty again, so the producer can reuse it.

The producer can skip a descriptor. The tail then waits on an empty descriptor that will never fill, while full descriptors sit further along the ring. A receive interrupt that arrives while the tail reads empty starts a forward scan for the next full descriptor, and the tail jumps there. The head later steps over the skipped descriptors, which are empty holes, without using a buffer on them. The engine has one read/write port into the ring's status storage and makes one access per clock cycle. It moves among three phases: tail service, head service and scan.

Top module: `rxr_engine`

## Requirements
- R1: Each descriptor status is a 2-bit code: 0 is empty, 1 is full and 2 is not-in-use. After reset the tail, head and scan pointers are all at descriptor 0, and no frame, refill or write is signalled. When traffic starts on an idle ring, the first frame is taken from descriptor 0.
- R2: While the tail descriptor reads full, `frm_valid` is high and `frm_idx` gives the tail index. Both hold steady until `frm_ready` is high. On that handshake the engine writes code 2 to the descriptor and moves the tail forward by one, wrapping from DEPTH-1 to 0. Frames leave in the order the producer filled them.
- R3: No frame is offered while the tail descriptor does not read full. Without a pending interrupt, the tail stays where it is.
- R4: When the head descriptor reads code 2 and lies behind the tail, and `buf_avail` is high, the engine pulses `buf_take` with `desc_addr` set to the head. In that same cycle it writes code 0 and moves the head forward. Refills occur in the same order as consumption.
- R5: While `buf_avail` is low, there is no `buf_take` and no refill write.
- R6: The head never passes the tail. The number of refills never exceeds the number of consumed frames, and once the head reaches the tail it stops.
- R7: A pulse on `rx_irq` is latched. If the tail then reads empty, the engine scans forward one descriptor per cycle, starting at the one after the tail. The first full descriptor it finds becomes the new tail, and consumption continues from it.
- R8: A scan checks at most the DEPTH-1 other descriptors. If none is full, the tail is left unchanged and `scan_empty` is set. It stays set until the next scan starts.
- R9: Empty descriptors lying between the head and the tail are holes left by a resync. The head steps over them with no `buf_take` and no write.
- R10: Once all traffic has drained and every buffer has been supplied, every descriptor reads empty, refills equal consumed frames, and the next frame comes from the descriptor where the producer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_addr | output | $clog2(DEPTH) | Index of the descriptor accessed this cycle |
| desc_rd | input | 2 | Status code read from `desc_addr` in the same cycle |
| desc_we | output | 1 | Write `desc_wdata` into the status at `desc_addr` |
| desc_wdata | output | 2 | Status code to write |
| frm_valid | output | 1 | A full descriptor is offered downstream |
| frm_idx | output | $clog2(DEPTH) | Index of the offered descriptor |
| frm_ready | input | 1 | Downstream accepts the offered frame |
| buf_avail | input | 1 | A fresh buffer can be attached |
| buf_take | output | 1 | A buffer is attached to `desc_addr` this cycle |
| rx_irq | input | 1 | Receive interrupt pulse that may start a scan |
| scan_empty | output | 1 | The last scan found no full descriptor |

## Verification
The main path is first tried with downstream stalled and no buffers available. This separates holding an offered frame, and keeping consumed descriptors not-in-use, from the refill action. A directed interrupt on a ring that has no full descriptors tells a scan that finds nothing apart from a scan that moves the tail. A producer skip followed by interrupts shows whether the tail jumps over exactly the hole and whether the head later steps over it with no buffer. A long random phase varies the fill rate, the downstream readiness, buffer availability and occasional holes. Expected frame and refill order is checked against queues kept by the bench, and a final drain checks that the ring returns to the idle state.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [1:0] {
      DS_EMPTY = 2'd0,
      DS_FULL  = 2'd1,
      DS_IDLE  = 2'd2
   } dstat_e;

   typedef enum logic [1:0] {
      PH_TAIL = 2'd0,
      PH_HEAD = 2'd1,
      PH_SCAN = 2'd2
   } phase_e;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   output logic [AW-1:0] ptr
);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [AW-1:0] nxt;

   generate
      if (POW2) begin : g_pow2
         assign nxt = ptr + AW'(1);
      end else begin : g_wrap
         assign nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (ld)  ptr <= ld_val;
      else if (inc) ptr <= nxt;
   end
endmodule

// File: rtl/rxr_gap_cnt.sv
module rxr_gap_cnt #(
   parameter int DEPTH = 16,
   parameter int GW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          add,
   input  logic [GW-1:0] add_val,
   output logic [GW-1:0] gap
);
   always_ff @(posedge clk) begin
      if (!rst_n)   gap <= '0;
      else if (add) gap <= gap + add_val;
      else if (inc) gap <= gap + GW'(1);
      else if (dec) gap <= gap - GW'(1);
   end
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
   import rxr_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int GW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    st,
   input  logic [AW-1:0] tail,
   input  logic [AW-1:0] head,
   input  logic [AW-1:0] scan,
   input  logic [GW-1:0] gap,
   input  logic          frm_ready,
   input  logic          buf_avail,
   input  logic          rx_irq,
   output logic [AW-1:0] desc_addr,
   output logic          desc_we,
   output logic [1:0]    desc_wdata,
   output logic          frm_valid,
   output logic          buf_take,
   output logic          tail_inc,
   output logic          tail_ld,
   output logic          head_inc,
   output logic          scan_ld,
   output logic [AW-1:0] scan_start,
   output logic          scan_inc,
   output logic          gap_inc,
   output logic          gap_dec,
   output logic          gap_add,
   output logic [GW-1:0] gap_add_val,
   output logic          scan_empty
);
   phase_e        ph_q, ph_d;
   logic          irq_q, irq_clr;
   logic [AW-1:0] cnt_q;
   logic          cnt_ld, cnt_inc, se_set, se_clr;

   assign scan_start  = (tail == AW'(DEPTH - 1)) ? '0 : tail + AW'(1);
   assign gap_add_val = GW'(cnt_q);

   always_comb begin
      ph_d       = ph_q;
      desc_addr  = tail;
      desc_we    = 1'b0;
      desc_wdata = DS_EMPTY;
      frm_valid  = 1'b0;
      buf_take   = 1'b0;
      tail_inc   = 1'b0;
      tail_ld    = 1'b0;
      head_inc   = 1'b0;
      scan_ld    = 1'b0;
      scan_inc   = 1'b0;
      gap_inc    = 1'b0;
      gap_dec    = 1'b0;
      gap_add    = 1'b0;
      irq_clr    = 1'b0;
      cnt_ld     = 1'b0;
      cnt_inc    = 1'b0;
      se_set     = 1'b0;
      se_clr     = 1'b0;
      unique case (ph_q)
         PH_TAIL: begin
            desc_addr = tail;
            if (st == DS_FULL) begin
               frm_valid = 1'b1;
               irq_clr   = 1'b1;
               if (frm_ready) begin
                  desc_we    = 1'b1;
                  desc_wdata = DS_IDLE;
                  tail_inc   = 1'b1;
                  gap_inc    = 1'b1;
                  ph_d       = PH_HEAD;
               end
            end else if (st == DS_EMPTY && irq_q) begin
               irq_clr = 1'b1;
               scan_ld = 1'b1;
               cnt_ld  = 1'b1;
               se_clr  = 1'b1;
               ph_d    = PH_SCAN;
            end else begin
               ph_d = PH_HEAD;
            end
         end
         PH_HEAD: begin
            desc_addr = head;
            ph_d      = PH_TAIL;
            if (gap != '0) begin
               if (st == DS_IDLE && buf_avail) begin
                  desc_we    = 1'b1;
                  desc_wdata = DS_EMPTY;
                  buf_take   = 1'b1;
                  head_inc   = 1'b1;
                  gap_dec    = 1'b1;
               end else if (st == DS_EMPTY) begin
                  head_inc = 1'b1;
                  gap_dec  = 1'b1;
               end
            end
         end
         PH_SCAN: begin
            desc_addr = scan;
            if (st == DS_FULL) begin
               tail_ld = 1'b1;
               gap_add = 1'b1;
               ph_d    = PH_TAIL;
            end else if (cnt_q == AW'(DEPTH - 1)) begin
               se_set = 1'b1;
               ph_d   = PH_TAIL;
            end else begin
               scan_inc = 1'b1;
               cnt_inc  = 1'b1;
            end
         end
         default: ph_d = PH_TAIL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= PH_TAIL;
         irq_q      <= 1'b0;
         cnt_q      <= '0;
         scan_empty <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (rx_irq)       irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
         if (cnt_ld)       cnt_q <= AW'(1);
         else if (cnt_inc) cnt_q <= cnt_q + AW'(1);
         if (se_set)       scan_empty <= 1'b1;
         else if (se_clr)  scan_empty <= 1'b0;
      end
   end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int GW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] desc_addr,
   input  logic [1:0]    desc_rd,
   output logic          desc_we,
   output logic [1:0]    desc_wdata,
   output logic          frm_valid,
   output logic [AW-1:0] frm_idx,
   input  logic          frm_ready,
   input  logic          buf_avail,
   output logic          buf_take,
   input  logic          rx_irq,
   output logic          scan_empty
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxr_engine: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0] tail, head, scan, scan_start;
   logic [GW-1:0] gap, gap_add_val;
   logic          tail_inc, tail_ld, head_inc, scan_ld, scan_inc;
   logic          gap_inc, gap_dec, gap_add;

   assign frm_idx = tail;

   rxr_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_tail (
      .clk(clk), .rst_n(rst_n), .inc(tail_inc), .ld(tail_ld),
      .ld_val(scan), .ptr(tail));

   rxr_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_head (
      .clk(clk), .rst_n(rst_n), .inc(head_inc), .ld(1'b0),
      .ld_val('0), .ptr(head));

   rxr_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_scan (
      .clk(clk), .rst_n(rst_n), .inc(scan_inc), .ld(scan_ld),
      .ld_val(scan_start), .ptr(scan));

   rxr_gap_cnt #(.DEPTH(DEPTH), .GW(GW)) u_gap (
      .clk(clk), .rst_n(rst_n), .inc(gap_inc), .dec(gap_dec),
      .add(gap_add), .add_val(gap_add_val), .gap(gap));

   rxr_ctrl #(.DEPTH(DEPTH), .AW(AW), .GW(GW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .st(desc_rd), .tail(tail), .head(head),
      .scan(scan), .gap(gap), .frm_ready(frm_ready), .buf_avail(buf_avail),
      .rx_irq(rx_irq), .desc_addr(desc_addr), .desc_we(desc_we),
      .desc_wdata(desc_wdata), .frm_valid(frm_valid), .buf_take(buf_take),
      .tail_inc(tail_inc), .tail_ld(tail_ld), .head_inc(head_inc),
      .scan_ld(scan_ld), .scan_start(scan_start), .scan_inc(scan_inc),
      .gap_inc(gap_inc), .gap_dec(gap_dec), .gap_add(gap_add),
      .gap_add_val(gap_add_val), .scan_empty(scan_empty));
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int GW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] desc_addr,
   input logic [1:0]    desc_rd,
   input logic          desc_we,
   input logic [1:0]    desc_wdata,
   input logic          frm_valid,
   input logic [AW-1:0] frm_idx,
   input logic          frm_ready,
   input logic          buf_avail,
   input logic          buf_take,
   input logic          scan_empty
);
   logic [GW-1:0] owed;
   always_ff @(posedge clk) begin
      if (!rst_n) owed <= '0;
      else if (frm_valid && frm_ready) owed <= owed + GW'(1);
      else if (buf_take) owed <= owed - GW'(1);
   end

   // R2: an offered frame holds until accepted
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_ready |=> frm_valid && $stable(frm_idx));

   // R2: acceptance retires the descriptor as not-in-use
   a_r2_retire: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_ready |-> desc_we && desc_wdata == 2'd2 && desc_addr == frm_idx);

   // R3: only a full descriptor is offered
   a_r3_full_only: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> desc_rd == 2'd1);

   // R4: a refill turns a not-in-use descriptor into an empty one
   a_r4_refill_write: assert property (@(posedge clk) disable iff (!rst_n)
      buf_take |-> desc_we && desc_wdata == 2'd0 && desc_rd == 2'd2);

   // R5: no refill without a buffer
   a_r5_no_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_avail |-> !buf_take);

   // R6: refills never outrun consumption
   a_r6_not_past: assert property (@(posedge clk) disable iff (!rst_n)
      buf_take |-> owed != '0);

   // R8: a failed scan leaves nothing offered
   a_r8_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_empty) |-> !frm_valid && !desc_we);
endmodule

bind rxr_engine rxr_engine_chk #(.DEPTH(DEPTH)) u_rxr_chk (
   .clk(clk), .rst_n(rst_n), .desc_addr(desc_addr), .desc_rd(desc_rd),
   .desc_we(desc_we), .desc_wdata(desc_wdata), .frm_valid(frm_valid),
   .frm_idx(frm_idx), .frm_ready(frm_ready), .buf_avail(buf_avail),
   .buf_take(buf_take), .scan_empty(scan_empty));

// File: tb/rxr_engine_tb_top.sv
module rxr_engine_tb_top;
   localparam int DEPTH = 16;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n;
   logic [AW-1:0] desc_addr;
   logic [1:0]    desc_rd;
   logic          desc_we;
   logic [1:0]    desc_wdata;
   logic          frm_valid;
   logic [AW-1:0] frm_idx;
   logic          frm_ready;
   logic          buf_avail;
   logic          buf_take;
   logic          rx_irq;
   logic          scan_empty;
   logic          irq_a, irq_h;

   logic [1:0] mem [DEPTH];
   logic       pw;
   int         pa;

   int errors = 0, checks = 0;
   int consumed = 0, refills = 0, cyc = 0;
   int exp_q[$], ref_q[$];
   int prod = 0, budget = 0, prod_rate = 100, hole_idx = 0;
   bit prod_en = 0, skip_req = 0, hole_act = 0, hole_irq_en = 0, done = 0;

   assign rx_irq  = irq_a | irq_h;
   assign desc_rd = mem[desc_addr];

   rxr_engine #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .desc_addr(desc_addr), .desc_rd(desc_rd),
      .desc_we(desc_we), .desc_wdata(desc_wdata), .frm_valid(frm_valid),
      .frm_idx(frm_idx), .frm_ready(frm_ready), .buf_avail(buf_avail),
      .buf_take(buf_take), .rx_irq(rx_irq), .scan_empty(scan_empty));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #3;
   endtask

   // ring status storage shared by the engine and the producer model
   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = 2'd0;
      pw = 1'b0;
      pa = 0;
   end
   always @(posedge clk) begin
      if (desc_we) mem[desc_addr] <= desc_wdata;
      if (pw) mem[pa] <= 2'd1;
   end

   // producer model: fills empty descriptors in order, sometimes skips one
   always @(posedge clk) begin
      #2;
      pw = 1'b0;
      cyc++;
      irq_h = hole_act && hole_irq_en && (cyc % 16 == 0);
      if (rst_n && prod_en && budget > 0 && mem[prod] == 2'd0 &&
          (exp_q.size() + ref_q.size() + int'(hole_act)) < DEPTH - 4 &&
          $urandom_range(99) < prod_rate) begin
         if (skip_req && !hole_act && ref_q.size() == 0) begin
            hole_act = 1'b1;
            hole_idx = prod;
            skip_req = 1'b0;
         end else begin
            pw = 1'b1;
            pa = prod;
            exp_q.push_back(prod);
            budget--;
         end
         prod = (prod + 1) % DEPTH;
      end
   end

   // port monitor: frame order, retire state, refill order
   always @(negedge clk) begin
      if (rst_n) begin
         if (frm_valid && frm_ready) begin
            int e;
            consumed++;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
            chk(int'(frm_idx) == e, "R2/R7", "frame index order", int'(frm_idx), e);
            chk(mem[frm_idx] == 2'd1, "R3", "offered descriptor full",
                int'(mem[frm_idx]), 1);
            ref_q.push_back(int'(frm_idx));
            if (hole_act && int'(frm_idx) == (hole_idx + 1) % DEPTH) hole_act = 1'b0;
         end
         if (buf_take) begin
            int e;
            refills++;
            chk(ref_q.size() > 0, "R6", "refill only behind tail", ref_q.size(), 1);
            e = (ref_q.size() > 0) ? ref_q.pop_front() : -1;
            chk(int'(desc_addr) == e, "R4/R9", "refill index order", int'(desc_addr), e);
            chk(mem[desc_addr] == 2'd2, "R4", "refilled descriptor not-in-use",
                int'(mem[desc_addr]), 2);
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0; frm_ready = 1'b0; buf_avail = 1'b0;
      irq_a = 1'b0; irq_h = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(!frm_valid && !buf_take && !desc_we && !scan_empty, "R1",
          "reset outputs quiet", int'({frm_valid, buf_take, desc_we, scan_empty}), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R1/R2: three frames, downstream stalled, no buffers
      budget = 3; prod_en = 1;
      wait_cyc(10);
      chk(frm_valid && frm_idx == 0, "R1", "first frame at descriptor 0", int'(frm_idx), 0);
      wait_cyc(3);
      chk(frm_valid && frm_idx == 0, "R2", "offer held while stalled", int'(frm_valid), 1);
      frm_ready = 1'b1;
      wait_cyc(20);
      chk(consumed == 3, "R2", "frames consumed", consumed, 3);
      for (int i = 0; i < 3; i++)
         chk(mem[i] == 2'd2, "R5", "retired stays not-in-use without buffer", int'(mem[i]), 2);
      chk(refills == 0, "R5", "no refill without buffer", refills, 0);

      // R4: buffers arrive
      buf_avail = 1'b1;
      wait_cyc(20);
      chk(refills == 3, "R4", "refills done", refills, 3);
      for (int i = 0; i < 3; i++)
         chk(mem[i] == 2'd0, "R4", "refilled descriptor empty", int'(mem[i]), 0);

      // R8: interrupt on a ring with no full descriptor
      @(posedge clk); #2 irq_a = 1'b1;
      @(posedge clk); #2 irq_a = 1'b0;
      wait_cyc(DEPTH + 10);
      chk(scan_empty == 1'b1, "R8", "scan_empty after empty lap", int'(scan_empty), 1);
      budget = 1;
      wait_cyc(15);
      chk(consumed == 4, "R8", "tail unchanged after failed scan", consumed, 4);
      chk(scan_empty == 1'b1, "R8", "flag holds until next scan", int'(scan_empty), 1);

      // R3/R7/R9: producer skips descriptor 4
      skip_req = 1; budget = 2;
      wait_cyc(30);
      chk(consumed == 4, "R3", "tail stalls on hole", consumed, 4);
      chk(frm_valid == 1'b0, "R3", "nothing offered at hole", int'(frm_valid), 0);
      hole_irq_en = 1;
      wait_cyc(60);
      chk(consumed == 6, "R7", "resync resumes consumption", consumed, 6);
      chk(scan_empty == 1'b0, "R7", "successful scan clears flag", int'(scan_empty), 0);
      chk(hole_act == 1'b0, "R7", "frame after hole consumed", int'(hole_act), 0);
      wait_cyc(20);
      chk(refills == 6, "R9", "hole stepped over without buffer", refills, 6);
      chk(mem[4] == 2'd0, "R9", "hole left empty", int'(mem[4]), 0);

      // R6: head caught up with tail
      frm_ready = 1'b0; budget = 1;
      wait_cyc(20);
      chk(refills == 6, "R6", "no refill past tail", refills, 6);
      frm_ready = 1'b1;
      wait_cyc(10);
      chk(refills == 7, "R6", "refill follows consume", refills, 7);

      // random phase
      budget = 1000000;
      for (int k = 0; k < 4000; k++) begin
         @(posedge clk); #3;
         frm_ready = ($urandom_range(99) < 70);
         buf_avail = ($urandom_range(99) < 60);
         if (k % 64 == 0) prod_rate = $urandom_range(100, 10);
         if (!hole_act && !skip_req && $urandom_range(299) == 0) skip_req = 1;
      end

      // drain: R10
      skip_req = 0; budget = 4; frm_ready = 1'b1; buf_avail = 1'b1;
      wait_cyc(400);
      chk(exp_q.size() == 0, "R10", "all frames delivered", exp_q.size(), 0);
      chk(ref_q.size() == 0, "R10", "all buffers attached", ref_q.size(), 0);
      chk(hole_act == 1'b0, "R10", "no hole pending", int'(hole_act), 0);
      chk(consumed == refills, "R10", "refills equal consumed", refills, consumed);
      for (int i = 0; i < DEPTH; i++)
         chk(mem[i] == 2'd0, "R10", "idle ring all empty", int'(mem[i]), 0);
      budget = 1;
      wait_cyc(20);
      chk(consumed == refills && exp_q.size() == 0, "R10", "idle ring resumes at producer",
          exp_q.size(), 0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule